// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the single active-low system reset for a supply supervisor. It combines two comparator flags with an optional push-button request. The flags are already synchronized to the block clock: one says the supply is under the trip level, the other says it is over the trip level plus hysteresis. The block runs from a slow free-running clock, and a one-microsecond tick strobe paces its timeout counter. Downstream logic receives the reset line and a one-cycle strobe that marks the moment reset lets go.

Reset is held while the supply is under the trip level or while an accepted manual request is present. Release needs the supply to clear the upper hysteresis level. A full timeout must then elapse without interruption, and any new fault during that wait throws the count away. The push-button input is synchronized and filtered against short low glitches. A build parameter can remove the manual path entirely. A second build parameter picks one of two timeout tables, and a select code that is captured when counting starts picks the entry. A divider parameter scales every table entry down by the same factor.

Top module: `supv_rst_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it rises, `rst_out_n` is 0 and `rst_rel` is 0.
- R2: If `sup_low` is sampled high at a clock edge, `rst_out_n` is 0 after that edge, and it stays 0 for as long as `sup_low` stays high.
- R3: Reset release starts only when `sup_ok_hys` is high. While both flags are low (the hysteresis band), an asserted reset stays asserted indefinitely. A released reset is not re-asserted by the band.
- R4: The edge that first samples no fault together with `sup_ok_hys` high starts the count. `rst_out_n` rises at the edge that counts the N-th `tick_us` pulse after that start, where N is the selected table entry divided by `TIME_DIV`. Cycles without a tick do not advance the count.
- R5: With `VARIANT`=0, codes 0, 1, 2 and 3 of `tmo_sel` select 100, 16000, 64000 and 128000 us. With `VARIANT`=1, codes 0 to 4 select 16000, 32000, 64000, 128000 and 256000 us. A code past the last entry selects the last entry. The code is captured at count start, and later changes to `tmo_sel` do not affect that count.
- R6: When `HAS_MANUAL`=1, a low level on `mr_n` held for at least `MR_FILT_CYC` cycles asserts reset. With the defaults, `rst_out_n` falls after the 7th edge following the change (`SYNC_STAGES`+`MR_FILT_CYC`+1). Reset stays asserted while `mr_n` is held low.
- R7: A low pulse on `mr_n` shorter than `MR_FILT_CYC` cycles leaves `rst_out_n` unchanged.
- R8: After an accepted release of `mr_n`, reset stays asserted for a full timeout. The count starts at the edge after the filter accepts the high level.
- R9: If `sup_low` or an accepted manual request appears during the count, the count is abandoned. A new full count starts only after the fault clears.
- R10: `rst_rel` is high for exactly one cycle: the first cycle in which `rst_out_n` is 1 after being 0. It is never high at any other time.
- R11: When `HAS_MANUAL`=0, `mr_n` has no effect on `rst_out_n` or `rst_rel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| sup_low | input | 1 | Synchronized flag: supply under trip level |
| sup_ok_hys | input | 1 | Synchronized flag: supply over trip level plus hysteresis |
| mr_n | input | 1 | Asynchronous manual reset request, active low, idle high |
| tmo_sel | input | SEL_W | Timeout table index, captured at count start |
| rst_out_n | output | 1 | System reset, active low |
| rst_rel | output | 1 | One-cycle strobe when reset deasserts |

## Verification
The bench builds two instances, and both use `TIME_DIV`=100. The first uses `VARIANT`=0 with the manual path and a 4-cycle filter. Its table becomes 1, 160, 640 and 1280 ticks, so the single-tick timeout, the out-of-range codes and the exact filter and synchronizer latency can all be reached in a few thousand cycles. The second uses `VARIANT`=1 without the manual path. Its table becomes 160 to 2560 ticks, which puts the longest entry and the fall-through code within reach, and the shared push-button input shows that this build ignores it.

// File: rtl/supv_pkg.sv
package supv_pkg;

   typedef enum logic [1:0] {
      SQ_HOLD = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_RUN  = 2'd2
   } seq_state_e;

   // table depth per variant
   function automatic int unsigned tbl_depth(input int variant);
      return (variant == 0) ? 4 : 5;
   endfunction

   // timeout table entry in microseconds
   function automatic int unsigned tmo_us(input int variant, input int idx);
      int unsigned v;
      if (variant == 0) begin
         case (idx)
            0:       v = 100;
            1:       v = 16000;
            2:       v = 64000;
            default: v = 128000;
         endcase
      end else begin
         case (idx)
            0:       v = 16000;
            1:       v = 32000;
            2:       v = 64000;
            3:       v = 128000;
            default: v = 256000;
         endcase
      end
      return v;
   endfunction

   function automatic int unsigned tmo_max_us(input int variant);
      return tmo_us(variant, 7);
   endfunction

   function automatic int unsigned tmo_min_us(input int variant);
      return tmo_us(variant, 0);
   endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/supv_glitch_filt.sv
module supv_glitch_filt #(
   parameter int   CYC  = 4,
   parameter logic INIT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int RUN_W = (CYC < 2) ? 1 : $clog2(CYC + 1);

   logic [RUN_W-1:0] run_q;
   logic             lvl_q;

   // a new level is taken only after CYC consecutive mismatching samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= INIT;
         run_q <= '0;
      end else if (d == lvl_q) begin
         run_q <= '0;
      end else if (run_q == RUN_W'(CYC - 1)) begin
         lvl_q <= d;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign q = lvl_q;
endmodule

// File: rtl/supv_tmo_ctr.sv
module supv_tmo_ctr
   import supv_pkg::*;
#(
   parameter int VARIANT  = 0,
   parameter int TIME_DIV = 1,
   parameter int SEL_W    = 3,
   parameter int CNT_W    = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             en,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam int DEPTH = int'(tbl_depth(VARIANT));

   logic [CNT_W-1:0] tbl [DEPTH];
   logic [CNT_W-1:0] lim_sel;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] cnt_q;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
      assign tbl[gi] = CNT_W'(tmo_us(VARIANT, gi) / TIME_DIV);
   end

   // codes past the end fall through to the last entry
   always_comb begin
      lim_sel = tbl[DEPTH-1];
      for (int i = DEPTH - 2; i >= 0; i--) begin
         if (sel == SEL_W'(i)) lim_sel = tbl[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q <= '0;
         cnt_q <= '0;
      end else if (start) begin
         lim_q <= lim_sel;
         cnt_q <= '0;
      end else if (en && tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = en && tick && (cnt_q == lim_q - 1'b1);
endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq
   import supv_pkg::*;
#(
   parameter int VARIANT     = 0,
   parameter int HAS_MANUAL  = 1,
   parameter int SYNC_STAGES = 2,
   parameter int MR_FILT_CYC = 4,
   parameter int TIME_DIV    = 1,
   parameter int SEL_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_us,
   input  logic             sup_low,
   input  logic             sup_ok_hys,
   input  logic             mr_n,
   input  logic [SEL_W-1:0] tmo_sel,
   output logic             rst_out_n,
   output logic             rst_rel
);
   localparam int MAX_TICKS = int'(tmo_max_us(VARIANT)) / TIME_DIV;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   initial begin
      assert (VARIANT == 0 || VARIANT == 1)
         else $error("VARIANT must be 0 or 1");
      assert (HAS_MANUAL == 0 || HAS_MANUAL == 1)
         else $error("HAS_MANUAL must be 0 or 1");
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      assert (MR_FILT_CYC >= 1)
         else $error("MR_FILT_CYC must be at least 1");
      assert (TIME_DIV >= 1 && (tmo_min_us(VARIANT) % TIME_DIV) == 0)
         else $error("TIME_DIV must divide the smallest table entry");
      assert ((1 << SEL_W) >= int'(tbl_depth(VARIANT)))
         else $error("SEL_W too narrow for the table");
   end

   logic mr_act;

   if (HAS_MANUAL != 0) begin : g_manual
      logic mr_sync;
      logic mr_filt;

      supv_sync #(
         .STAGES (SYNC_STAGES),
         .RST_VAL(1'b1)
      ) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (mr_n),
         .q    (mr_sync)
      );

      supv_glitch_filt #(
         .CYC (MR_FILT_CYC),
         .INIT(1'b1)
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (mr_sync),
         .q    (mr_filt)
      );

      assign mr_act = ~mr_filt;
   end else begin : g_no_manual
      assign mr_act = 1'b0;
   end

   seq_state_e st_q;
   seq_state_e st_nxt;
   logic       hold;
   logic       cnt_start;
   logic       cnt_en;
   logic       expire;
   logic       rst_q;
   logic       rel_q;

   assign hold   = sup_low || mr_act;
   assign cnt_en = (st_q == SQ_WAIT) && !hold;

   supv_tmo_ctr #(
      .VARIANT (VARIANT),
      .TIME_DIV(TIME_DIV),
      .SEL_W   (SEL_W),
      .CNT_W   (CNT_W)
   ) u_tmo (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cnt_start),
      .en    (cnt_en),
      .tick  (tick_us),
      .sel   (tmo_sel),
      .expire(expire)
   );

   always_comb begin
      st_nxt    = st_q;
      cnt_start = 1'b0;
      case (st_q)
         SQ_HOLD: begin
            if (!hold && sup_ok_hys) begin
               st_nxt    = SQ_WAIT;
               cnt_start = 1'b1;
            end
         end
         SQ_WAIT: begin
            if (hold)        st_nxt = SQ_HOLD;
            else if (expire) st_nxt = SQ_RUN;
         end
         SQ_RUN: begin
            if (hold) st_nxt = SQ_HOLD;
         end
         default: st_nxt = SQ_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_HOLD;
         rst_q <= 1'b0;
         rel_q <= 1'b0;
      end else begin
         st_q  <= st_nxt;
         rst_q <= (st_nxt == SQ_RUN);
         rel_q <= (st_q == SQ_WAIT) && (st_nxt == SQ_RUN);
      end
   end

   assign rst_out_n = rst_q;
   assign rst_rel   = rel_q;
endmodule

// File: rtl/supv_rst_seq_chk.sv
module supv_rst_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sup_low,
   input logic mr_act,
   input logic rst_out_n,
   input logic rst_rel
);
   // R2: a sampled under-voltage flag forces reset on the next cycle
   p_low_forces_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sup_low |=> !rst_out_n);

   // R6: an accepted manual request forces reset on the next cycle
   p_manual_forces_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mr_act |=> !rst_out_n);

   // R3: a release follows a cycle with no fault present
   p_release_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> $past(!sup_low && !mr_act));

   // R10: strobe only on the first released cycle
   p_strobe_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_rel |-> (rst_out_n && !$past(rst_out_n)));

   // R10: every release carries the strobe
   p_rise_has_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> rst_rel);

   // R10: strobe lasts one cycle
   p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_rel |=> !rst_rel);
endmodule

bind supv_rst_seq supv_rst_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sup_low  (sup_low),
   .mr_act   (mr_act),
   .rst_out_n(rst_out_n),
   .rst_rel  (rst_rel)
);

// File: tb/supv_ref_model.sv
module supv_ref_model #(
   parameter int VARIANT    = 0,
   parameter int HAS_MANUAL = 1,
   parameter int FILT       = 4,
   parameter int DIV        = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       sup_low,
   input  logic       sup_hi,
   input  logic       mr_n,
   input  logic [2:0] sel,
   output logic       exp_rst,
   output logic       exp_rel
);
   bit stage1, stage2, pressed, counting;
   int diff_run, elapsed, target;

   // timeout in ticks derived from the requirement table
   function automatic int limit(input int s);
      int us;
      if (VARIANT == 0) us = (s == 0) ? 100 : (s == 1) ? 16000 : (s == 2) ? 64000 : 128000;
      else us = (s == 0) ? 16000 : (s == 1) ? 32000 : (s == 2) ? 64000 :
                (s == 3) ? 128000 : 256000;
      return us / DIV;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      bit fault;
      bit want_low;
      if (!rst_n) begin
         stage1 = 1; stage2 = 1; pressed = 0; diff_run = 0;
         counting = 0; elapsed = 0; target = 0;
         exp_rst = 0; exp_rel = 0;
      end else begin
         fault = sup_low || (HAS_MANUAL != 0 && pressed);
         exp_rel = 0;
         if (fault) begin
            counting = 0;
            exp_rst  = 0;
         end else if (!exp_rst) begin
            if (!counting) begin
               if (sup_hi) begin
                  counting = 1;
                  elapsed  = 0;
                  target   = limit(int'(sel));
               end
            end else if (tick) begin
               elapsed++;
               if (elapsed == target) begin
                  exp_rst  = 1;
                  exp_rel  = 1;
                  counting = 0;
               end
            end
         end
         want_low = (stage2 == 0);
         if (want_low != pressed) begin
            diff_run++;
            if (diff_run == FILT) begin
               pressed  = want_low;
               diff_run = 0;
            end
         end else begin
            diff_run = 0;
         end
         stage2 = stage1;
         stage1 = mr_n;
      end
   end
endmodule

// File: tb/supv_rst_seq_tb.sv
module supv_rst_seq_tb;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       tick = 1;
   logic       sup_low = 1;
   logic       sup_hi = 0;
   logic       mr_n = 1;
   logic [2:0] sel_a = 3'd1;
   logic [2:0] sel_b = 3'd0;
   logic       ra, la, rb, lb;
   logic       ea, ela, eb, elb;
   int         n_cmp = 0;
   int         n_bad = 0;
   int         cyc = 0;
   bit         cmp_on = 0;
   bit         done = 0;

   always #4 clk = ~clk;

   supv_rst_seq #(.VARIANT(0), .HAS_MANUAL(1), .MR_FILT_CYC(4), .TIME_DIV(100)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_us(tick), .sup_low(sup_low), .sup_ok_hys(sup_hi),
      .mr_n(mr_n), .tmo_sel(sel_a), .rst_out_n(ra), .rst_rel(la));

   supv_rst_seq #(.VARIANT(1), .HAS_MANUAL(0), .MR_FILT_CYC(4), .TIME_DIV(100)) u_dut_b (
      .clk(clk), .rst_n(rst_n), .tick_us(tick), .sup_low(sup_low), .sup_ok_hys(sup_hi),
      .mr_n(mr_n), .tmo_sel(sel_b), .rst_out_n(rb), .rst_rel(lb));

   supv_ref_model #(.VARIANT(0), .HAS_MANUAL(1), .FILT(4), .DIV(100)) u_ref_a (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sup_low(sup_low), .sup_hi(sup_hi),
      .mr_n(mr_n), .sel(sel_a), .exp_rst(ea), .exp_rel(ela));

   supv_ref_model #(.VARIANT(1), .HAS_MANUAL(0), .FILT(4), .DIV(100)) u_ref_b (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sup_low(sup_low), .sup_hi(sup_hi),
      .mr_n(mr_n), .sel(sel_b), .exp_rst(eb), .exp_rel(elb));

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // 0 = under trip, 1 = hysteresis band, 2 = above hysteresis
   task automatic set_level(input int lv);
      sup_low = (lv == 0);
      sup_hi  = (lv == 2);
   endtask

   // continuous comparison against the reference model
   always @(negedge clk) begin
      if (cmp_on) begin
         check("R4 reset level a", ra, ea);
         check("R10 strobe a", la, ela);
         check("R11 reset level b", rb, eb);
         check("R10 strobe b", lb, elb);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 190000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish (cycle %0d)", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seg_end;
      void'($urandom(32'd20240611));
      set_level(0);
      step(3);
      check("R1 reset during por", ra, 1'b0);
      check("R1 strobe during por", la, 1'b0);
      check("R1 reset b during por", rb, 1'b0);
      rst_n = 1;
      cmp_on = 1;
      step(5);
      check("R2 held while low", ra, 1'b0);
      check("R1 no strobe after por", la, 1'b0);

      // R3: band does not release
      set_level(1);
      step(40);
      check("R3 band keeps reset", ra, 1'b0);

      // R4: single-tick entry, no progress without ticks
      sel_a = 3'd0;
      tick = 0;
      set_level(2);
      step(30);
      check("R4 no ticks no release", ra, 1'b0);
      tick = 1;
      step(1);
      check("R4 release after one tick", ra, 1'b1);
      check("R10 strobe on release", la, 1'b1);
      step(1);
      check("R10 strobe one cycle", la, 1'b0);
      check("R10 reset stays released", ra, 1'b1);

      // R3: band after release keeps it released
      set_level(1);
      step(20);
      check("R3 band keeps release", ra, 1'b1);
      set_level(2);

      // R2: immediate assertion
      set_level(0);
      step(1);
      check("R2 assert next edge", ra, 1'b0);
      step(10);
      check("R2 held while low", ra, 1'b0);

      // R5: code captured at start, 160 ticks
      sel_a = 3'd1;
      set_level(2);
      step(1);
      sel_a = 3'd0;
      step(159);
      check("R5 captured code still counting", ra, 1'b0);
      step(1);
      check("R5 release at 160 ticks", ra, 1'b1);

      // R5: code beyond table uses last entry (1280 ticks)
      sel_a = 3'd5;
      set_level(0);
      step(2);
      set_level(2);
      step(1280);
      check("R5 beyond table still counting", ra, 1'b0);
      step(1);
      check("R5 beyond table release", ra, 1'b1);

      // R7: three-cycle glitch rejected
      mr_n = 0;
      step(3);
      mr_n = 1;
      step(15);
      check("R7 glitch ignored", ra, 1'b1);

      // R6: press accepted after 7 edges
      mr_n = 0;
      step(6);
      check("R6 not yet asserted", ra, 1'b1);
      step(1);
      check("R6 asserted by press", ra, 1'b0);
      step(50);
      check("R6 held while pressed", ra, 1'b0);
      check("R11 press ignored without manual path", rb, 1'b1);
      check("R11 no strobe without manual path", lb, 1'b0);

      // R8: full timeout from release
      sel_a = 3'd1;
      mr_n = 1;
      step(166);
      check("R8 still asserted", ra, 1'b0);
      step(1);
      check("R8 released after timeout", ra, 1'b1);

      // R9: interruption restarts count
      set_level(0);
      step(2);
      set_level(2);
      step(80);
      set_level(0);
      step(1);
      set_level(2);
      step(160);
      check("R9 restarted count running", ra, 1'b0);
      step(1);
      check("R9 release after full recount", ra, 1'b1);

      // random phase, checked against the model every cycle
      for (int seg = 0; seg < 100000 && cyc < 90000; seg++) begin
         int lv_pick;
         int dur;
         lv_pick = $urandom_range(0, 9);
         set_level(lv_pick < 2 ? 0 : (lv_pick < 3 ? 1 : 2));
         if ($urandom_range(0, 3) == 0) sel_a = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 3) == 0) sel_b = 3'($urandom_range(0, 7));
         dur = ($urandom_range(0, 9) < 7) ? $urandom_range(1, 200) : $urandom_range(200, 3000);
         seg_end = cyc + dur;
         while (cyc < seg_end) begin
            tick = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 99) < 3) mr_n = ~mr_n;
            step(1);
         end
         mr_n = 1;
      end

      cmp_on = 0;
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule